// File: doc/BRIEF.md
# Windowed output pixel address generator

This block sits between a pixel source that produces 16-bit RGB565 pixels with their X/Y image coordinates and a memory writer. It pairs each even-X pixel with the odd-X pixel that follows it and forms one 32-bit word. For every word it computes a byte address inside a frame buffer. Pixels outside a programmable crop rectangle are dropped. The crop origin is moved to the first address of the output. Output lines are spaced by a programmable line pitch.

Every word address is checked against a destination window bounded below and above. When a word would land outside that window, the block holds the word, raises a full flag and stops accepting pixels. It resumes only after the host has rewritten a window register and then writes 1 to the flag. The held word is then retried with the new settings.

The host reaches the settings through a small word-addressed register port. Register offsets: 0x0 status (bit 0 = full, write 1 to clear), 0x1 crop X start, 0x2 crop Y start, 0x3 crop X end, 0x4 crop Y end, 0x5 window low, 0x6 window high, 0x7 shift, 0x8 line pitch, 0xE current word address (read only).

The control state machine has four states:
- `ST_EVEN`: waiting for the even pixel of a pair. It goes to `ST_ODD` when a kept even pixel is accepted.
- `ST_ODD`: holding the even pixel.
  - A kept even pixel replaces the held one and the state stays `ST_ODD`.
  - A kept odd pixel completes the word. The state goes to `ST_EVEN` if the address is inside the window, otherwise to `ST_HOLD`.
- `ST_HOLD`: suspended with the word held. It goes to `ST_RETRY` on a clear that follows a window rewrite.
- `ST_RETRY`: re-evaluates the held word with the current settings. It goes to `ST_EVEN` and writes the word if the address is inside the window, otherwise back to `ST_HOLD`.

Top module: `jpx_word_addr_gen`

## Requirements
- R1: Each kept odd-X pixel that follows a kept even-X pixel produces one word write, one cycle after the odd pixel is accepted. `wr_data[15:0]` is the even pixel and `wr_data[31:16]` is the odd pixel. Every write address has bits 1..0 equal to 0.
- R2: The word address is computed as `window_low - shift + (rx + pitch*ry)*2`, where rx and ry are the even pixel's X and Y minus the crop start X and crop start Y.
- R3: When the line pitch register (offset 0x8) holds 0, the effective pitch is `img_w` with bit 0 cleared.
- R4: A host write forces bit 0 to 0 for crop X start, crop X end and pitch. It forces bits 1..0 to 0 for window low, window high and shift. The stored values read back at their offsets.
- R5: A pixel is kept only when all of the following hold; otherwise it is dropped with no effect:
  - crop X start ≤ x < X end;
  - crop Y start ≤ y < Y end.
  
  An X end of 0 means `img_w` with bit 0 cleared. A Y end of 0 means `img_h`.
- R6: A pixel whose relative X is at least the effective pitch is dropped.
- R7: A word is written only when window low ≤ address < window high. Otherwise:
  - no write is made;
  - `win_full` and status bit 0 go to 1;
  - `pix_ready` goes to 0.
- R8: In the full state, a rewrite of window low, window high or shift followed by a write of 1 to status bit 0 retries the held word with the new settings. The retry write appears two cycles after the clearing write's clock edge.
- R9: Writing 1 to status bit 0 while full, without a window rewrite since the flag was raised, is ignored and the flag stays set.
- R10: Offset 0xE reads the last computed word address, including a blocked one. It reads 0 after reset.
- R11: After reset:
  - all settings read 0;
  - `win_full` and `wr_valid` are 0;
  - `pix_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 4 | Host register word offset |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data for `reg_addr` (combinational) |
| img_w | input | 16 | Image width in pixels |
| img_h | input | 16 | Image height in pixels |
| pix_valid | input | 1 | Pixel present |
| pix_ready | output | 1 | Block accepts pixels (low while suspended) |
| pix_x | input | 16 | Pixel X coordinate |
| pix_y | input | 16 | Pixel Y coordinate |
| pix_data | input | 16 | RGB565 pixel value |
| wr_valid | output | 1 | One-cycle word write strobe |
| wr_addr | output | 32 | Byte address of the word |
| wr_data | output | 32 | Packed pixel pair |
| win_full | output | 1 | Destination window full, output suspended |

## Verification
Directed raster scans check three cases:
- A tight window whose high bound equals a word address shows that the upper bound is exclusive.
- A nonzero shift pushes the first word below window low, which tells the subtracted shift apart from an added one.
- A zero pitch with an odd image width shows that the fallback drops bit 0.

Random frames vary the image size, crop rectangle and pitch. Crops narrower than the pitch separate crop dropping from pitch dropping. Pitches narrower than the crop separate the discard rule from simple line wrapping. Each suspend is released once by a bare clear, which must be ignored, and once by a clear after a rewrite, which must retry the held word with the new address.

// File: rtl/jpx_pkg.sv
package jpx_pkg;
    typedef enum logic [1:0] {
        ST_EVEN  = 2'd0,
        ST_ODD   = 2'd1,
        ST_HOLD  = 2'd2,
        ST_RETRY = 2'd3
    } pack_state_t;

    localparam logic [3:0] OFS_STATUS = 4'h0;
    localparam logic [3:0] OFS_CX0    = 4'h1;
    localparam logic [3:0] OFS_CY0    = 4'h2;
    localparam logic [3:0] OFS_CX1    = 4'h3;
    localparam logic [3:0] OFS_CY1    = 4'h4;
    localparam logic [3:0] OFS_WLO    = 4'h5;
    localparam logic [3:0] OFS_WHI    = 4'h6;
    localparam logic [3:0] OFS_SHIFT  = 4'h7;
    localparam logic [3:0] OFS_PITCH  = 4'h8;
    localparam logic [3:0] OFS_CURADR = 4'hE;
endpackage

// File: rtl/jpx_cfg_regs.sv
module jpx_cfg_regs
    import jpx_pkg::*;
#(
    parameter int CW = 16,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [3:0]    addr,
    input  logic [AW-1:0] wdata,
    input  logic [AW-1:0] cur_addr,
    input  logic          full,
    output logic [CW-1:0] crop_x0,
    output logic [CW-1:0] crop_y0,
    output logic [CW-1:0] crop_x1,
    output logic [CW-1:0] crop_y1,
    output logic [CW-1:0] pitch,
    output logic [AW-1:0] win_lo,
    output logic [AW-1:0] win_hi,
    output logic [AW-1:0] shift,
    output logic          win_wr,
    output logic          clr_req,
    output logic [AW-1:0] rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crop_x0 <= '0;
            crop_y0 <= '0;
            crop_x1 <= '0;
            crop_y1 <= '0;
            pitch   <= '0;
            win_lo  <= '0;
            win_hi  <= '0;
            shift   <= '0;
        end else if (we) begin
            case (addr)
                OFS_CX0:   crop_x0 <= {wdata[CW-1:1], 1'b0};
                OFS_CY0:   crop_y0 <= wdata[CW-1:0];
                OFS_CX1:   crop_x1 <= {wdata[CW-1:1], 1'b0};
                OFS_CY1:   crop_y1 <= wdata[CW-1:0];
                OFS_PITCH: pitch   <= {wdata[CW-1:1], 1'b0};
                OFS_WLO:   win_lo  <= {wdata[AW-1:2], 2'b00};
                OFS_WHI:   win_hi  <= {wdata[AW-1:2], 2'b00};
                OFS_SHIFT: shift   <= {wdata[AW-1:2], 2'b00};
                default: ;
            endcase
        end
    end

    always_comb begin
        win_wr  = we && (addr == OFS_WLO || addr == OFS_WHI || addr == OFS_SHIFT);
        clr_req = we && (addr == OFS_STATUS) && wdata[0];
        case (addr)
            OFS_STATUS: rdata = AW'(full);
            OFS_CX0:    rdata = AW'(crop_x0);
            OFS_CY0:    rdata = AW'(crop_y0);
            OFS_CX1:    rdata = AW'(crop_x1);
            OFS_CY1:    rdata = AW'(crop_y1);
            OFS_PITCH:  rdata = AW'(pitch);
            OFS_WLO:    rdata = win_lo;
            OFS_WHI:    rdata = win_hi;
            OFS_SHIFT:  rdata = shift;
            OFS_CURADR: rdata = cur_addr;
            default:    rdata = '0;
        endcase
    end

    // R4
    lsb_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (crop_x0[0] == 1'b0 && crop_x1[0] == 1'b0 && pitch[0] == 1'b0 &&
         win_lo[1:0] == 2'b00 && win_hi[1:0] == 2'b00 && shift[1:0] == 2'b00));
endmodule

// File: rtl/jpx_area_filter.sv
module jpx_area_filter #(
    parameter int CW = 16
) (
    input  logic [CW-1:0] x,
    input  logic [CW-1:0] y,
    input  logic [CW-1:0] img_w,
    input  logic [CW-1:0] img_h,
    input  logic [CW-1:0] crop_x0,
    input  logic [CW-1:0] crop_y0,
    input  logic [CW-1:0] crop_x1,
    input  logic [CW-1:0] crop_y1,
    input  logic [CW-1:0] pitch_raw,
    output logic          keep,
    output logic [CW-1:0] rel_x,
    output logic [CW-1:0] rel_y,
    output logic [CW-1:0] pitch_eff
);
    localparam logic [CW-1:0] EVEN_MASK = ~CW'(1);

    logic [CW-1:0] w_even;
    logic [CW-1:0] x_end;
    logic [CW-1:0] y_end;

    always_comb begin
        w_even    = img_w & EVEN_MASK;
        x_end     = (crop_x1 == '0) ? w_even : crop_x1;
        y_end     = (crop_y1 == '0) ? img_h : crop_y1;
        pitch_eff = (pitch_raw == '0) ? w_even : pitch_raw;
        rel_x     = x - crop_x0;
        rel_y     = y - crop_y0;
        keep      = (x >= crop_x0) && (x < x_end) &&
                    (y >= crop_y0) && (y < y_end) &&
                    (rel_x < pitch_eff);
    end
endmodule

// File: rtl/jpx_addr_calc.sv
module jpx_addr_calc #(
    parameter int CW = 16,
    parameter int AW = 32
) (
    input  logic [CW-1:0] rel_x,
    input  logic [CW-1:0] rel_y,
    input  logic [CW-1:0] pitch,
    input  logic [AW-1:0] win_lo,
    input  logic [AW-1:0] win_hi,
    input  logic [AW-1:0] shift,
    output logic [AW-1:0] addr,
    output logic          in_win
);
    logic [AW-1:0] lin;

    always_comb begin
        lin    = AW'(rel_x) + AW'(pitch) * AW'(rel_y);
        addr   = win_lo - shift + (lin << 1);
        in_win = (addr >= win_lo) && (addr < win_hi);
    end
endmodule

// File: rtl/jpx_pack_fsm.sv
module jpx_pack_fsm
    import jpx_pkg::*;
#(
    parameter int CW = 16,
    parameter int AW = 32,
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_valid,
    input  logic          pix_keep,
    input  logic          pix_odd,
    input  logic [CW-1:0] rel_x,
    input  logic [CW-1:0] rel_y,
    input  logic [PW-1:0] pix_data,
    input  logic [AW-1:0] calc_addr,
    input  logic          calc_in_win,
    input  logic          clr_req,
    input  logic          win_wr,
    output logic          pix_ready,
    output logic          full,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [2*PW-1:0] wr_data,
    output logic [AW-1:0] cur_addr,
    output logic [CW-1:0] ev_rx,
    output logic [CW-1:0] ev_ry
);
    pack_state_t state_q, nxt;
    logic [PW-1:0] lo_pix, hi_pix;
    logic reprog_q;
    logic accept, take_even, take_odd;

    assign pix_ready = (state_q == ST_EVEN) || (state_q == ST_ODD);
    assign full      = (state_q == ST_HOLD);

    always_comb begin
        accept    = pix_valid && pix_ready;
        take_even = accept && pix_keep && !pix_odd;
        take_odd  = accept && pix_keep && pix_odd && (state_q == ST_ODD);
        nxt       = state_q;
        unique case (state_q)
            ST_EVEN:  if (take_even) nxt = ST_ODD;
            ST_ODD:   if (take_odd) nxt = calc_in_win ? ST_EVEN : ST_HOLD;
            ST_HOLD:  if (clr_req && reprog_q) nxt = ST_RETRY;
            ST_RETRY: nxt = calc_in_win ? ST_EVEN : ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EVEN;
        else        state_q <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            cur_addr <= '0;
            lo_pix   <= '0;
            hi_pix   <= '0;
            ev_rx    <= '0;
            ev_ry    <= '0;
            reprog_q <= 1'b0;
        end else begin
            wr_valid <= 1'b0;
            if (take_even) begin
                lo_pix <= pix_data;
                ev_rx  <= rel_x;
                ev_ry  <= rel_y;
            end
            if (take_odd) begin
                hi_pix   <= pix_data;
                cur_addr <= calc_addr;
                if (calc_in_win) begin
                    wr_valid <= 1'b1;
                    wr_addr  <= calc_addr;
                    wr_data  <= {pix_data, lo_pix};
                end
            end
            if (state_q == ST_RETRY) begin
                cur_addr <= calc_addr;
                if (calc_in_win) begin
                    wr_valid <= 1'b1;
                    wr_addr  <= calc_addr;
                    wr_data  <= {hi_pix, lo_pix};
                end
            end
            if (state_q != ST_HOLD && nxt == ST_HOLD) reprog_q <= 1'b0;
            else if (state_q == ST_HOLD && win_wr)    reprog_q <= 1'b1;
        end
    end

    // R7
    hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> !wr_valid);
    // R9
    clear_needs_reprog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !reprog_q) |=> full);
    // R8
    resume_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(full) |=> (wr_valid || full));
endmodule

// File: rtl/jpx_word_addr_gen.sv
module jpx_word_addr_gen #(
    parameter int CW = 16,
    parameter int AW = 32,
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [3:0]    reg_addr,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    input  logic [CW-1:0] img_w,
    input  logic [CW-1:0] img_h,
    input  logic          pix_valid,
    output logic          pix_ready,
    input  logic [CW-1:0] pix_x,
    input  logic [CW-1:0] pix_y,
    input  logic [PW-1:0] pix_data,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [2*PW-1:0] wr_data,
    output logic          win_full
);
    logic [CW-1:0] crop_x0, crop_y0, crop_x1, crop_y1, pitch_raw, pitch_eff;
    logic [AW-1:0] win_lo, win_hi, shift, cur_addr, calc_addr;
    logic [CW-1:0] rel_x, rel_y, ev_rx, ev_ry;
    logic          win_wr, clr_req, keep, calc_in_win;

    jpx_cfg_regs #(.CW(CW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .cur_addr(cur_addr), .full(win_full),
        .crop_x0(crop_x0), .crop_y0(crop_y0), .crop_x1(crop_x1), .crop_y1(crop_y1),
        .pitch(pitch_raw), .win_lo(win_lo), .win_hi(win_hi), .shift(shift),
        .win_wr(win_wr), .clr_req(clr_req), .rdata(reg_rdata)
    );

    jpx_area_filter #(.CW(CW)) u_filter (
        .x(pix_x), .y(pix_y), .img_w(img_w), .img_h(img_h),
        .crop_x0(crop_x0), .crop_y0(crop_y0), .crop_x1(crop_x1), .crop_y1(crop_y1),
        .pitch_raw(pitch_raw), .keep(keep), .rel_x(rel_x), .rel_y(rel_y),
        .pitch_eff(pitch_eff)
    );

    jpx_addr_calc #(.CW(CW), .AW(AW)) u_calc (
        .rel_x(ev_rx), .rel_y(ev_ry), .pitch(pitch_eff),
        .win_lo(win_lo), .win_hi(win_hi), .shift(shift),
        .addr(calc_addr), .in_win(calc_in_win)
    );

    jpx_pack_fsm #(.CW(CW), .AW(AW), .PW(PW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_keep(keep),
        .pix_odd(pix_x[0]), .rel_x(rel_x), .rel_y(rel_y), .pix_data(pix_data),
        .calc_addr(calc_addr), .calc_in_win(calc_in_win),
        .clr_req(clr_req), .win_wr(win_wr),
        .pix_ready(pix_ready), .full(win_full), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .cur_addr(cur_addr),
        .ev_rx(ev_rx), .ev_ry(ev_ry)
    );

    // R1
    wr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_addr[1:0] == 2'b00));
    // R7
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_full |-> !pix_ready);
endmodule

// File: tb/test_jpx_word_addr_gen.sv
module test_jpx_word_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [3:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic [15:0] img_w, img_h, pix_x, pix_y, pix_data;
    logic        pix_valid, pix_ready, wr_valid, win_full;
    logic [31:0] wr_addr, wr_data;

    always #5 clk = ~clk;

    jpx_word_addr_gen i_jpx_word_addr_gen (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .img_w(img_w), .img_h(img_h),
        .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_x(pix_x), .pix_y(pix_y),
        .pix_data(pix_data), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .win_full(win_full)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // shadows of programmed settings, with the write forcing of R4 applied
    logic [15:0] s_x0 = 0, s_y0 = 0, s_x1 = 0, s_y1 = 0, s_pitch = 0;
    logic [31:0] s_lo = 0, s_hi = 0, s_sh = 0;
    // pairing model
    bit          m_have = 0;
    logic [15:0] m_d, m_rx, m_ry;
    logic [15:0] p_rx, p_ry;
    logic [31:0] p_data, p_addr;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pitch_eff();
        return (s_pitch == 0) ? (img_w & 16'hFFFE) : s_pitch;
    endfunction

    function automatic bit keep_px(input logic [15:0] x, input logic [15:0] y);
        logic [15:0] xe, ye, rx;
        xe = (s_x1 == 0) ? (img_w & 16'hFFFE) : s_x1;
        ye = (s_y1 == 0) ? img_h : s_y1;
        rx = x - s_x0;
        return (x >= s_x0) && (x < xe) && (y >= s_y0) && (y < ye) && (rx < pitch_eff());
    endfunction

    function automatic logic [31:0] exp_addr(input logic [15:0] rx, input logic [15:0] ry);
        return s_lo - s_sh + ((32'(rx) + 32'(pitch_eff()) * 32'(ry)) << 1);
    endfunction

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        case (a)
            4'h1: s_x0 = d[15:0] & 16'hFFFE;
            4'h2: s_y0 = d[15:0];
            4'h3: s_x1 = d[15:0] & 16'hFFFE;
            4'h4: s_y1 = d[15:0];
            4'h5: s_lo = d & 32'hFFFF_FFFC;
            4'h6: s_hi = d & 32'hFFFF_FFFC;
            4'h7: s_sh = d & 32'hFFFF_FFFC;
            4'h8: s_pitch = d[15:0] & 16'hFFFE;
            default: ;
        endcase
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic send_pix(input logic [15:0] x, input logic [15:0] y, input logic [15:0] d);
        bit exp_wr, exp_full;
        logic [31:0] a, v;
        @(negedge clk);
        pix_valid = 1'b1; pix_x = x; pix_y = y; pix_data = d;
        @(negedge clk);
        pix_valid = 1'b0;
        exp_wr = 0; exp_full = 0;
        if (keep_px(x, y)) begin
            if (!x[0]) begin
                m_have = 1; m_d = d; m_rx = x - s_x0; m_ry = y - s_y0;
            end else if (m_have) begin
                m_have = 0;
                a = exp_addr(m_rx, m_ry);
                if (a >= s_lo && a < s_hi) begin
                    exp_wr = 1;
                    chk("R2 word address", wr_addr, a);
                    chk("R1 packed data", wr_data, {d, m_d});
                end else begin
                    exp_full = 1;
                    p_rx = m_rx; p_ry = m_ry; p_data = {d, m_d}; p_addr = a;
                end
            end
        end
        chk("R1 R5 R6 write strobe", 32'(wr_valid), 32'(exp_wr));
        if (exp_full) begin
            chk("R7 full flag", 32'(win_full), 32'd1);
            chk("R7 pixel stall", 32'(pix_ready), 32'd0);
            rd_reg(4'h0, v);
            chk("R7 status bit", v, 32'd1);
            rd_reg(4'hE, v);
            chk("R10 blocked address readback", v, p_addr);
        end
    endtask

    // bare clear (ignored), then rewrite + clear (retry)
    task automatic recover(input logic [3:0] a, input logic [31:0] d);
        logic [31:0] ea;
        wr_reg(4'h0, 32'd1);
        @(negedge clk);
        chk("R9 bare clear ignored", 32'(win_full), 32'd1);
        wr_reg(a, d);
        wr_reg(4'h0, 32'd1);
        @(negedge clk);
        ea = exp_addr(p_rx, p_ry);
        chk("R8 retry strobe", 32'(wr_valid), 32'd1);
        chk("R8 retry address", wr_addr, ea);
        chk("R8 retry data", wr_data, p_data);
        chk("R8 full released", 32'(win_full), 32'd0);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R11 watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd12345));
        rst_n = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
        img_w = 16'd8; img_h = 16'd4; pix_valid = 0; pix_x = 0; pix_y = 0; pix_data = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // reset state
        chk("R11 full after reset", 32'(win_full), 32'd0);
        chk("R11 ready after reset", 32'(pix_ready), 32'd1);
        chk("R11 no write after reset", 32'(wr_valid), 32'd0);
        rd_reg(4'hE, v); chk("R10 address resets to 0", v, 32'd0);
        rd_reg(4'h6, v); chk("R11 window high resets to 0", v, 32'd0);
        rd_reg(4'h0, v); chk("R11 status resets to 0", v, 32'd0);

        // LSB forcing
        wr_reg(4'h1, 32'h0000_0005); rd_reg(4'h1, v); chk("R4 crop x start bit0", v, 32'h4);
        wr_reg(4'h3, 32'h0000_0007); rd_reg(4'h3, v); chk("R4 crop x end bit0", v, 32'h6);
        wr_reg(4'h8, 32'h0000_0007); rd_reg(4'h8, v); chk("R4 pitch bit0", v, 32'h6);
        wr_reg(4'h5, 32'h0000_1003); rd_reg(4'h5, v); chk("R4 window low bits", v, 32'h1000);
        wr_reg(4'h6, 32'h0000_100B); rd_reg(4'h6, v); chk("R4 window high bits", v, 32'h1008);
        wr_reg(4'h7, 32'h0000_0002); rd_reg(4'h7, v); chk("R4 shift bits", v, 32'h0);

        // exclusive upper bound
        wr_reg(4'h1, 0); wr_reg(4'h3, 0); wr_reg(4'h8, 0);
        send_pix(0, 0, 16'hA000); send_pix(1, 0, 16'hA001);
        send_pix(2, 0, 16'hA002); send_pix(3, 0, 16'hA003);
        send_pix(4, 0, 16'hA004); send_pix(5, 0, 16'hA005);
        chk("R7 upper bound is exclusive", 32'(win_full), 32'd1);
        recover(4'h6, 32'h0000_2000);

        // shift pushes first word below window low
        wr_reg(4'h7, 32'h8);
        send_pix(0, 0, 16'hB000); send_pix(1, 0, 16'hB001);
        chk("R2 shift subtracts", p_addr, 32'h0000_0FF8);
        recover(4'h7, 32'h0);
        chk("R8 retry lands at window low", wr_addr, 32'h1000);

        // pitch fallback with odd width
        img_w = 16'd7;
        send_pix(2, 1, 16'hC002); send_pix(3, 1, 16'hC003);
        chk("R3 pitch fallback address", wr_addr, 32'h1010);

        // random frames
        wr_reg(4'h5, 32'h0000_4000); wr_reg(4'h6, 32'hFFFF_0000);
        for (int f = 0; f < 30; f++) begin
            logic [15:0] w, h;
            w = 16'(4 + $urandom % 17);
            h = 16'(2 + $urandom % 5);
            img_w = w; img_h = h;
            if ($urandom % 3 == 0) begin
                wr_reg(4'h1, 0); wr_reg(4'h2, 0); wr_reg(4'h3, 0); wr_reg(4'h4, 0);
            end else begin
                wr_reg(4'h1, 32'(($urandom % (w / 4 + 1)) * 2));
                wr_reg(4'h3, 32'(s_x0 + 2 + 2 * ($urandom % (((w & 16'hFFFE) - s_x0) / 2))));
                wr_reg(4'h2, 32'($urandom % h));
                wr_reg(4'h4, 32'(s_y0 + 1 + $urandom % (h - s_y0)));
            end
            wr_reg(4'h8, ($urandom % 2 == 0) ? 32'd0 : 32'(2 + 2 * ($urandom % 12)));
            for (int y = 0; y < 32'(h); y++)
                for (int x = 0; x < 32'(w); x++)
                    send_pix(16'(x), 16'(y), 16'($urandom));
        end

        done = 1;
        summary();
        $finish;
    end
endmodule